// File: doc/BRIEF.md
# Dual-Tone Melody Sequencer

The block plays songs kept in a note memory of up to 1024 words of 22 bits. A host writes the notes and a table of song start addresses, then selects one of 31 songs, sets a tempo and a busy-reporting mode, and pulses start. The sequencer reads the song one note at a time. Each note carries two pitch codes, one for each square-wave tone channel. The note sounds for a time set by its beat code and the current tempo. A stop pulse ends playback at once.

Each pitch code selects a half-period, counted in cycles of the playing clock. The clock input `clk_i` is the playing clock. A channel output toggles each time its counter completes that half-period. The two tone bits are also summed into a 2-bit level for a downstream PWM stage. A per-note tremolo bit gates both tones on and off at a fixed slow rate. A busy flag clears either after every note or only after the whole song, and an interrupt pulse marks each time the flag clears.

Top module: `melody_seq`

## Requirements
- R1: After reset, tone_a_o, tone_b_o, mix_o, playing_o, busy_o and irq_o are all 0.
- R2: A start_i pulse while idle, with song_i not 0, begins playback at the address held in table entry song_i, and playing_o is 1 from the next cycle. A start with song_i = 0 is ignored, and so is a start while playing.
- R3: Note word fields: [5:0] channel A pitch, [11:6] channel B pitch, [14:12] beat code, [15] tremolo, [16] last note of song, [21:17] unused. Notes are read at consecutive addresses that wrap from 1023 to 0. The note with bit 16 set is the last one played.
- R4: A note sounds for mult × (16 − tempo) × 256 cycles. Beat codes 0..5 give mult 1, 2, 3, 4, 6 and 8, and codes 6 and 7 give 8. tempo_i is sampled as each note begins. Successive notes are separated by two fetch cycles.
- R5: Pitch codes 1..41 give a half-period of B[(c−1) mod 12] >> ((c−1) div 12) cycles, with B = 7224, 6818, 6436, 6074, 5733, 5412, 5108, 4821, 4551, 4295, 4054, 3827. Codes 0 and 42..63 are rests. A sounding channel starts low at note start and first rises one half-period later.
- R6: A 16-bit tremolo counter clears when a song starts and advances every cycle while playing. While the note's tremolo bit is set and counter bit 15 is 1, both tones are forced to 0.
- R7: mix_o equals tone_a_o + tone_b_o as a 2-bit value, so a resting channel adds 0.
- R8: song_busy_i is sampled at start. With 0, busy_o is 1 only while a note sounds. With 1, busy_o is 1 from the cycle after start until the song ends.
- R9: irq_o is a one-cycle pulse in the first cycle in which busy_o is 0 after having been 1.
- R10: A stop_i pulse returns the block to idle by the next cycle and takes priority over start_i.
- R11: While playing_o is 0, both tones and mix_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Playing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| note_we_i | input | 1 | Note memory write strobe |
| note_waddr_i | input | 10 | Note memory write address |
| note_wdata_i | input | 22 | Note word to write |
| tbl_we_i | input | 1 | Song table write strobe |
| tbl_idx_i | input | 5 | Song table entry to write |
| tbl_addr_i | input | 10 | Start address written to the entry |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| song_i | input | 5 | Song selected at start |
| tempo_i | input | 4 | Tempo setting, sampled per note |
| song_busy_i | input | 1 | Busy mode: 0 per note, 1 per song |
| tone_a_o | output | 1 | Channel A square wave |
| tone_b_o | output | 1 | Channel B square wave |
| mix_o | output | 2 | Sum of the two tone bits |
| playing_o | output | 1 | Song in progress |
| busy_o | output | 1 | Busy flag in the selected mode |
| irq_o | output | 1 | Pulse when the busy flag clears |

## Verification
Assertions check on every cycle that the tones and mix are silent when idle, that busy never stands without playback, that the interrupt is a single pulse on a busy fall, and that stop and song-0 starts leave the block idle. Only the bench scenarios can show the half-periods of each pitch code, the note lengths for each beat and tempo, tempo sampling per note, address wrap, tremolo muting inside a long song, and the busy-cycle and interrupt totals of the two busy modes.

// File: rtl/mel_pkg.sv
package mel_pkg;
  localparam int NOTE_W    = 22;
  localparam int PITCH_W   = 6;
  localparam int BEAT_W    = 3;
  localparam int MULT_W    = 4;
  localparam int HP_W      = 13;
  localparam int NUM_PITCH = 41;
  localparam int OCT_LEN   = 12;

  typedef struct packed {
    logic [4:0]         spare;
    logic               last;
    logic               trem;
    logic [BEAT_W-1:0]  beat;
    logic [PITCH_W-1:0] pitch_b;
    logic [PITCH_W-1:0] pitch_a;
  } note_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_PLAY} seq_st_e;

  function automatic logic [MULT_W-1:0] beat_mult(input logic [BEAT_W-1:0] b);
    case (b)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      3'd4:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  // top octave entries derived by shifting the lowest octave
  function automatic logic [HP_W-1:0] half_period(input logic [PITCH_W-1:0] code);
    logic [PITCH_W-1:0] k;
    logic [2:0]         oct;
    logic [3:0]         idx;
    logic [HP_W-1:0]    base;
    if (code == '0 || int'(code) > NUM_PITCH) return '0;
    k   = code - PITCH_W'(1);
    oct = 3'(int'(k) / OCT_LEN);
    idx = 4'(int'(k) % OCT_LEN);
    case (idx)
      4'd0:    base = 13'd7224;
      4'd1:    base = 13'd6818;
      4'd2:    base = 13'd6436;
      4'd3:    base = 13'd6074;
      4'd4:    base = 13'd5733;
      4'd5:    base = 13'd5412;
      4'd6:    base = 13'd5108;
      4'd7:    base = 13'd4821;
      4'd8:    base = 13'd4551;
      4'd9:    base = 13'd4295;
      4'd10:   base = 13'd4054;
      default: base = 13'd3827;
    endcase
    return base >> oct;
  endfunction
endpackage

// File: rtl/mel_note_mem.sv
module mel_note_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 22
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/mel_song_tbl.sv
module mel_song_tbl #(
  parameter int SONG_W = 5,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SONG_W-1:0] widx_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [SONG_W-1:0] ridx_i,
  output logic [ADDR_W-1:0] raddr_o
);
  localparam int SONGS = 1 << SONG_W;

  logic [ADDR_W-1:0] ent_q [SONGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SONGS; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[widx_i] <= waddr_i;
    end
  end

  assign raddr_o = ent_q[ridx_i];
endmodule

// File: rtl/mel_tone_gen.sv
module mel_tone_gen
  import mel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               run_i,
  input  logic               gate_i,
  input  logic [PITCH_W-1:0] code_i,
  output logic               tone_o
);
  logic [PITCH_W-1:0] code_q;
  logic [HP_W-1:0]    cnt_q;
  logic [HP_W-1:0]    hp;
  logic               out_q;

  assign hp = half_period(code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else if (load_i) begin
      code_q <= code_i;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else if (run_i && hp != '0) begin
      if (cnt_q == hp - HP_W'(1)) begin
        cnt_q <= '0;
        out_q <= ~out_q;
      end else begin
        cnt_q <= cnt_q + HP_W'(1);
      end
    end
  end

  assign tone_o = out_q & run_i & gate_i & (hp != '0);
endmodule

// File: rtl/mel_seq_ctrl.sv
module mel_seq_ctrl
  import mel_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SONG_W     = 5,
  parameter int TEMPO_W    = 4,
  parameter int UNIT_SHIFT = 8,
  parameter int TREM_BIT   = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [SONG_W-1:0]  song_i,
  input  logic [TEMPO_W-1:0] tempo_i,
  input  logic               song_busy_i,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic [BEAT_W-1:0]  beat_i,
  input  logic               trem_i,
  input  logic               last_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               load_o,
  output logic               run_o,
  output logic               gate_o,
  output logic               playing_o,
  output logic               busy_o,
  output logic               irq_o
);
  localparam int SPAN_W = TEMPO_W + 1;
  localparam int DUR_W  = BEAT_W + TEMPO_W + UNIT_SHIFT + 1;
  localparam int TRM_W  = TREM_BIT + 1;

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DUR_W-1:0]  dur_q, dur_load, dur_prod;
  logic [SPAN_W-1:0] span;
  logic [TRM_W-1:0]  trm_q;
  logic              trem_q, last_q, mode_q, mode_d, irq_q;
  logic              accept, note_done, busy_d;

  assign accept    = (st_q == ST_IDLE) && start_i && !stop_i && (song_i != '0);
  assign note_done = (st_q == ST_PLAY) && (dur_q == '0);

  assign span     = SPAN_W'(1 << TEMPO_W) - {1'b0, tempo_i};
  assign dur_prod = DUR_W'(beat_mult(beat_i)) * DUR_W'(span);
  assign dur_load = (dur_prod << UNIT_SHIFT) - DUR_W'(1);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_LOAD;
      ST_LOAD:  st_d = ST_PLAY;
      ST_PLAY:  if (note_done) st_d = last_q ? ST_IDLE : ST_FETCH;
      default:  st_d = ST_IDLE;
    endcase
    if (stop_i) st_d = ST_IDLE;
  end

  assign mode_d = accept ? song_busy_i : mode_q;
  assign busy_d = mode_d ? (st_d != ST_IDLE) : (st_d == ST_PLAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      dur_q  <= '0;
      trm_q  <= '0;
      trem_q <= 1'b0;
      last_q <= 1'b0;
      mode_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      irq_q  <= busy_o & ~busy_d;
      if (accept) addr_q <= start_addr_i;
      else if (note_done && !last_q) addr_q <= addr_q + ADDR_W'(1);
      if (accept) trm_q <= '0;
      else if (st_q != ST_IDLE) trm_q <= trm_q + TRM_W'(1);
      if (st_q == ST_LOAD) begin
        dur_q  <= dur_load;
        trem_q <= trem_i;
        last_q <= last_i;
      end else if (st_q == ST_PLAY && dur_q != '0) begin
        dur_q <= dur_q - DUR_W'(1);
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign load_o    = (st_q == ST_LOAD);
  assign run_o     = (st_q == ST_PLAY);
  assign gate_o    = ~(trem_q & trm_q[TREM_BIT]);
  assign playing_o = (st_q != ST_IDLE);
  assign busy_o    = mode_q ? (st_q != ST_IDLE) : (st_q == ST_PLAY);
  assign irq_o     = irq_q;
endmodule

// File: rtl/melody_seq.sv
module melody_seq
  import mel_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SONG_W     = 5,
  parameter int TEMPO_W    = 4,
  parameter int UNIT_SHIFT = 8,
  parameter int TREM_BIT   = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               note_we_i,
  input  logic [ADDR_W-1:0]  note_waddr_i,
  input  logic [NOTE_W-1:0]  note_wdata_i,
  input  logic               tbl_we_i,
  input  logic [SONG_W-1:0]  tbl_idx_i,
  input  logic [ADDR_W-1:0]  tbl_addr_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [SONG_W-1:0]  song_i,
  input  logic [TEMPO_W-1:0] tempo_i,
  input  logic               song_busy_i,
  output logic               tone_a_o,
  output logic               tone_b_o,
  output logic [1:0]         mix_o,
  output logic               playing_o,
  output logic               busy_o,
  output logic               irq_o
);
  localparam int NUM_CH = 2;

  logic [ADDR_W-1:0] start_addr, rd_addr;
  logic [NOTE_W-1:0] rd_raw;
  note_t             rd_note;
  logic              load, run, gate;
  logic [NUM_CH-1:0] tones;
  logic [NUM_CH-1:0][PITCH_W-1:0] codes;

  mel_song_tbl #(.SONG_W(SONG_W), .ADDR_W(ADDR_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(tbl_we_i), .widx_i(tbl_idx_i), .waddr_i(tbl_addr_i),
    .ridx_i(song_i), .raddr_o(start_addr)
  );

  mel_note_mem #(.ADDR_W(ADDR_W), .DATA_W(NOTE_W)) u_mem (
    .clk_i,
    .we_i(note_we_i), .waddr_i(note_waddr_i), .wdata_i(note_wdata_i),
    .raddr_i(rd_addr), .rdata_o(rd_raw)
  );

  assign rd_note = note_t'(rd_raw);

  mel_seq_ctrl #(
    .ADDR_W(ADDR_W), .SONG_W(SONG_W), .TEMPO_W(TEMPO_W),
    .UNIT_SHIFT(UNIT_SHIFT), .TREM_BIT(TREM_BIT)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .song_i, .tempo_i, .song_busy_i,
    .start_addr_i(start_addr),
    .beat_i(rd_note.beat), .trem_i(rd_note.trem), .last_i(rd_note.last),
    .rd_addr_o(rd_addr), .load_o(load), .run_o(run), .gate_o(gate),
    .playing_o, .busy_o, .irq_o
  );

  assign codes = {rd_note.pitch_b, rd_note.pitch_a};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    mel_tone_gen u_tone (
      .clk_i, .rst_ni,
      .load_i(load), .run_i(run), .gate_i(gate),
      .code_i(codes[ch]), .tone_o(tones[ch])
    );
  end

  assign tone_a_o = tones[0];
  assign tone_b_o = tones[1];
  assign mix_o    = {1'b0, tones[0]} + {1'b0, tones[1]};
endmodule

// File: rtl/mel_seq_chk.sv
module mel_seq_chk #(
  parameter int SONG_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic [SONG_W-1:0] song_i,
  input logic              tone_a_o,
  input logic              tone_b_o,
  input logic [1:0]        mix_o,
  input logic              playing_o,
  input logic              busy_o,
  input logic              irq_o
);
  p_silent_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !playing_o |-> (!tone_a_o && !tone_b_o && mix_o == 2'd0));

  p_busy_in_song_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> playing_o);

  p_irq_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!busy_o && $past(busy_o)));

  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_stop_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !playing_o);

  p_song0_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!playing_o && start_i && song_i == '0) |=> !playing_o);
endmodule

bind melody_seq mel_seq_chk #(.SONG_W(SONG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .song_i(song_i), .tone_a_o(tone_a_o), .tone_b_o(tone_b_o), .mix_o(mix_o),
  .playing_o(playing_o), .busy_o(busy_o), .irq_o(irq_o)
);

// File: tb/tb_melody_seq.sv
module tb_melody_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        note_we_i = 1'b0;
  logic [9:0]  note_waddr_i = '0;
  logic [21:0] note_wdata_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [4:0]  tbl_idx_i = '0;
  logic [9:0]  tbl_addr_i = '0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [4:0]  song_i = '0;
  logic [3:0]  tempo_i = 4'd15;
  logic        song_busy_i = 1'b0;
  logic        tone_a_o, tone_b_o, playing_o, busy_o, irq_o;
  logic [1:0]  mix_o;

  always #2 clk = ~clk;

  melody_seq dut (
    .clk_i(clk), .rst_ni, .note_we_i, .note_waddr_i, .note_wdata_i,
    .tbl_we_i, .tbl_idx_i, .tbl_addr_i, .start_i, .stop_i, .song_i,
    .tempo_i, .song_busy_i, .tone_a_o, .tone_b_o, .mix_o,
    .playing_o, .busy_o, .irq_o
  );

  int total = 0, bad = 0;
  int n, busy_cnt, irq_cnt, rise_a, rise_b, hi_win, mix_bad;
  int tempo_at, tempo_new, start_at, stop_at, win_lo, win_hi;

  // a, b, beat, tempo, mode, half-period A, half-period B, duration
  localparam int NV = 7;
  localparam int VEC [NV][8] = '{
    '{41, 37, 3, 15, 0,  716,  903, 1024},
    '{40,  0, 2, 14, 0,  759,    0, 1536},
    '{30, 41, 4, 15, 1, 1353,  716, 1536},
    '{13,  0, 5, 14, 0, 3612,    0, 4096},
    '{ 1,  0, 1,  0, 0, 7224,    0, 8192},
    '{ 0, 41, 0, 12, 1,    0,  716, 1024},
    '{42, 41, 6, 15, 0,    0,  716, 2048}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [21:0] note_word(input int a, input int b, input int beat,
                                            input bit trem, input bit last);
    return {5'b0, last, trem, 3'(beat), 6'(b), 6'(a)};
  endfunction

  task automatic wr_note(input int addr, input logic [21:0] w);
    @(negedge clk);
    note_we_i = 1'b1; note_waddr_i = 10'(addr); note_wdata_i = w;
    @(negedge clk);
    note_we_i = 1'b0;
  endtask

  task automatic wr_tbl(input int idx, input int addr);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_idx_i = 5'(idx); tbl_addr_i = 10'(addr);
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  task automatic clear_hooks();
    tempo_at = -1; start_at = -1; stop_at = -1; win_lo = -1; win_hi = -2;
  endtask

  task automatic run_song(input int song, input bit mode);
    busy_cnt = 0; irq_cnt = 0; rise_a = -1; rise_b = -1; hi_win = 0; mix_bad = 0;
    @(negedge clk);
    song_i = 5'(song); song_busy_i = mode; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; n = 0;
    while (n < 60000) begin
      if (busy_o) busy_cnt++;
      if (irq_o) irq_cnt++;
      if (tone_a_o && rise_a < 0) rise_a = n;
      if (tone_b_o && rise_b < 0) rise_b = n;
      if (tone_a_o && n >= win_lo && n <= win_hi) hi_win++;
      if (mix_o != ({1'b0, tone_a_o} + {1'b0, tone_b_o})) mix_bad++;
      if (!playing_o) break;
      if (n == tempo_at) tempo_i = 4'(tempo_new);
      start_i = (n == start_at);
      if (n == start_at) song_i = 5'd2;
      stop_i = (n == stop_at);
      @(negedge clk);
      n++;
    end
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_hooks();
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk("R1 outputs in reset", {tone_a_o, tone_b_o, mix_o, playing_o, busy_o, irq_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {tone_a_o, tone_b_o, mix_o, playing_o, busy_o, irq_o}, 0);

    // R5 R4 R7 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      wr_note(100 + v, note_word(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, 1'b1));
      wr_tbl(1, 100 + v);
      tempo_i = 4'(VEC[v][3]);
      clear_hooks();
      run_song(1, VEC[v][4] != 0);
      chk($sformatf("R5 v%0d channel A first rise", v), rise_a,
          VEC[v][5] == 0 ? -1 : VEC[v][5] + 2);
      chk($sformatf("R5 v%0d channel B first rise", v), rise_b,
          VEC[v][6] == 0 ? -1 : VEC[v][6] + 2);
      chk($sformatf("R4 R8 v%0d busy cycles", v), busy_cnt,
          VEC[v][4] != 0 ? VEC[v][7] + 2 : VEC[v][7]);
      chk($sformatf("R9 v%0d irq pulses", v), irq_cnt, 1);
      chk($sformatf("R7 v%0d mix mismatches", v), mix_bad, 0);
    end

    // R2 song 0 ignored
    clear_hooks();
    run_song(0, 1'b1);
    chk("R2 song 0 start ignored", n, 0);
    chk("R2 song 0 busy", busy_cnt, 0);

    // R3 R4 three-note song, tempo changed during first note
    wr_note(200, note_word(41, 0, 1, 1'b0, 1'b0));
    wr_note(201, note_word(40, 0, 0, 1'b0, 1'b0));
    wr_note(202, note_word(37, 0, 7, 1'b0, 1'b1));
    wr_tbl(2, 200);
    tempo_i = 4'd15;
    clear_hooks(); tempo_at = 5; tempo_new = 14;
    run_song(2, 1'b0);
    chk("R4 per-note busy sum, tempo per note", busy_cnt, 5120);
    chk("R9 per-note irq count", irq_cnt, 3);
    chk("R3 song end cycle", n, 5126);

    // R8 song mode, R2 start while playing ignored
    tempo_i = 4'd15;
    clear_hooks(); tempo_at = 5; tempo_new = 14; start_at = 100;
    run_song(2, 1'b1);
    chk("R8 song-mode busy cycles", busy_cnt, 5126);
    chk("R9 song-mode irq count", irq_cnt, 1);
    chk("R2 restart ignored, end cycle", n, 5126);

    // R3 address wrap 1023 -> 0
    wr_note(1023, note_word(41, 0, 0, 1'b0, 1'b0));
    wr_note(0, note_word(0, 41, 3, 1'b0, 1'b1));
    wr_tbl(4, 1023);
    tempo_i = 4'd15;
    clear_hooks();
    run_song(4, 1'b0);
    chk("R3 wrap irq count", irq_cnt, 2);
    chk("R3 wrap second note B rise", rise_b, 976);
    chk("R3 wrap end cycle", n, 1284);

    // R10 stop mid-note
    wr_tbl(1, 103);
    tempo_i = 4'd14;
    clear_hooks(); stop_at = 50;
    run_song(1, 1'b0);
    chk("R10 stop end cycle", n, 51);
    chk("R10 busy before stop", busy_cnt, 49);
    chk("R9 irq on stop", irq_cnt, 1);
    chk("R11 mix after stop", int'(mix_o), 0);

    // R6 tremolo muting in second note
    wr_note(300, note_word(41, 0, 5, 1'b0, 1'b0));
    wr_note(301, note_word(41, 0, 0, 1'b1, 1'b1));
    wr_tbl(3, 300);
    tempo_i = 4'd0;
    clear_hooks(); win_lo = 32772; win_hi = 36867;
    run_song(3, 1'b0);
    chk("R6 first note sounds", rise_a, 718);
    chk("R6 tremolo note muted", hi_win, 0);
    chk("R6 song end cycle", n, 36868);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule